// File: doc/BRIEF.md
# Segmented Delay-Line Fine-Time Encoder

This block turns one snapshot of a tapped delay line into a fine time code. The snapshot is a wide vector of taps that were latched together on the system clock. Bit i of each segment is 1 when the launched edge has already passed tap i. Where the pattern turns from ones to zeros marks how far the edge travelled inside the clock window. Real snapshots are not clean thermometer codes: metastability and uneven tap delays leave isolated wrong bits, called bubbles. The encoder therefore filters each tap against its neighbours before it looks for the transition.

The line is split into several equal sub-lines. Each sub-line yields its own transition position, and the fine code is the sum of those positions. With the default of four segments of 80 taps, the code spans 4 to 316, which is more than 300 bins for one clock window.

Snapshots enter on a valid/ready stream, and results leave on a valid/ready stream. Each accepted snapshot gives exactly one result, in order. When the consumer holds `out_ready` low while a result is waiting, the whole two-stage pipeline freezes. `in_ready` then drops, so the producer must keep its snapshot and `in_valid` until a cycle where `in_ready` is high. A result that is waiting keeps its value until it is taken.

Top module: `tdl_fine_encoder`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` is 1 exactly when `out_ready` is 1 or `out_valid` is 0. A transfer on either side happens only in a cycle where both valid and ready are 1.
- R3: Inside each segment, every interior tap is replaced by the majority of itself and its two neighbouring taps. The first and last tap of a segment are used unchanged. Segment s holds bits [s*SEG_TAPS +: SEG_TAPS] of `in_taps`, with tap 0 as the lowest bit.
- R4: The position of a segment is i+1, where i is the lowest index at which the filtered tap i is 1 and tap i+1 is 0. So a position always lies in the range 1 to SEG_TAPS-1.
- R5: If any segment has no such 1-to-0 transition, the result has `out_hit` = 0 and `out_code` = 0. This covers a segment that is all ones, all zeros, or only rises.
- R6: If every segment has a transition, the result has `out_hit` = 1 and `out_code` equal to the sum of the segment positions. This sum lies between NSEG and NSEG*(SEG_TAPS-1).
- R7: A snapshot accepted at a clock edge, with `out_ready` high in the following cycle, appears with `out_valid` = 1 right after the next edge. That is a latency of two register stages.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_hit` and `out_code` stay unchanged at the next edge.
- R9: Every accepted snapshot produces exactly one result, and results leave in the order the snapshots were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; taps are sampled on it |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Tap snapshot present |
| in_ready | output | 1 | Encoder can accept a snapshot |
| in_taps | input | NSEG*SEG_TAPS | Sampled taps, segment s in bits [s*SEG_TAPS +: SEG_TAPS] |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer accepts the result |
| out_hit | output | 1 | Every segment showed a transition |
| out_code | output | CODE_W | Fine time code, sum of segment positions |

## Verification
The bench builds the encoder with its defaults: four segments of 80 taps and a 9-bit code. With these values the full code range, up to 316, can be reached, and so can the boundaries between segments, where filtering must not look across. Directed snapshots place every segment at position 1 and at position 79, leave a single segment empty, and set bubbles at end taps and on adjacent pairs. Random snapshots with flipped bits and random back-pressure then exercise the filter, the stall behaviour and the result order.

// File: rtl/tdl_enc_pkg.sv
package tdl_enc_pkg;
  // two-of-three vote used by the bubble filter
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/tdl_bubble_vote.sv
module tdl_bubble_vote #(
  parameter int W = 80
) (
  input  logic [W-1:0] raw,
  output logic [W-1:0] clean
);
  import tdl_enc_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_tap
    if (i == 0 || i == W - 1) begin : g_end
      assign clean[i] = raw[i];
    end else begin : g_mid
      assign clean[i] = maj3(raw[i-1], raw[i], raw[i+1]);
    end
  end
endmodule

// File: rtl/tdl_edge_locate.sv
module tdl_edge_locate #(
  parameter int W  = 80,
  parameter int PW = $clog2(W)
) (
  input  logic [W-1:0]  clean,
  output logic [PW-1:0] pos,
  output logic          found
);
  always_comb begin
    pos   = '0;
    found = 1'b0;
    // scan downwards so the lowest falling point wins
    for (int i = W - 2; i >= 0; i--) begin
      if (clean[i] && !clean[i+1]) begin
        pos   = PW'(i + 1);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tdl_code_merge.sv
module tdl_code_merge #(
  parameter int NSEG   = 4,
  parameter int POS_W  = 7,
  parameter int CODE_W = 9
) (
  input  logic [NSEG*POS_W-1:0] pos_flat,
  input  logic [NSEG-1:0]       found,
  output logic                  hit,
  output logic [CODE_W-1:0]     code
);
  logic [CODE_W-1:0] sum;

  always_comb begin
    sum = '0;
    for (int s = 0; s < NSEG; s++) begin
      sum = sum + CODE_W'(pos_flat[s*POS_W +: POS_W]);
    end
  end

  assign hit  = &found;
  assign code = hit ? sum : '0;
endmodule

// File: rtl/tdl_fine_encoder.sv
module tdl_fine_encoder #(
  parameter int NSEG     = 4,
  parameter int SEG_TAPS = 80,
  localparam int TAPS    = NSEG * SEG_TAPS,
  localparam int POS_W   = $clog2(SEG_TAPS),
  localparam int CODE_W  = $clog2(NSEG * (SEG_TAPS - 1) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [TAPS-1:0]   in_taps,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_hit,
  output logic [CODE_W-1:0] out_code
);
  localparam int MAX_CODE = NSEG * (SEG_TAPS - 1);

  logic                  adv;
  logic [NSEG*POS_W-1:0] pos_d, pos_q;
  logic [NSEG-1:0]       fnd_d, fnd_q;
  logic                  v1_q;
  logic                  hit_d;
  logic [CODE_W-1:0]     code_d;

  // the whole pipe moves together unless a finished result is blocked
  assign adv      = out_ready || !out_valid;
  assign in_ready = adv;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic [SEG_TAPS-1:0] clean;

    tdl_bubble_vote #(.W(SEG_TAPS)) u_vote (
      .raw   (in_taps[s*SEG_TAPS +: SEG_TAPS]),
      .clean (clean)
    );

    tdl_edge_locate #(.W(SEG_TAPS), .PW(POS_W)) u_loc (
      .clean (clean),
      .pos   (pos_d[s*POS_W +: POS_W]),
      .found (fnd_d[s])
    );

    // R4
    seg_pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (v1_q && fnd_q[s]) |-> (pos_q[s*POS_W +: POS_W] != '0 &&
                              32'(pos_q[s*POS_W +: POS_W]) < SEG_TAPS));
  end

  // stage 1: per-segment positions
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1_q  <= 1'b0;
      pos_q <= '0;
      fnd_q <= '0;
    end else if (adv) begin
      v1_q <= in_valid;
      if (in_valid) begin
        pos_q <= pos_d;
        fnd_q <= fnd_d;
      end
    end
  end

  tdl_code_merge #(.NSEG(NSEG), .POS_W(POS_W), .CODE_W(CODE_W)) u_merge (
    .pos_flat (pos_q),
    .found    (fnd_q),
    .hit      (hit_d),
    .code     (code_d)
  );

  // stage 2: merged result
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_code  <= '0;
    end else if (adv) begin
      out_valid <= v1_q;
      if (v1_q) begin
        out_hit  <= hit_d;
        out_code <= code_d;
      end
    end
  end

  // R6
  hit_code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_hit) |-> (32'(out_code) >= NSEG && 32'(out_code) <= MAX_CODE));

  // R7
  two_stage_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 out_ready |=> out_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code) && $stable(out_hit)));
endmodule

// File: tb/tdl_fine_encoder_test.sv
module tdl_fine_encoder_test;
  localparam int NSEG = 4;
  localparam int SEG  = 80;
  localparam int TAPS = NSEG * SEG;
  localparam int CW   = 9;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [TAPS-1:0] in_taps = '0;
  logic            out_valid;
  logic            out_ready = 1'b0;
  logic            out_hit;
  logic [CW-1:0]   out_code;

  int n_checks = 0;
  int n_fail   = 0;

  logic          exp_hit_q[$];
  logic [CW-1:0] exp_code_q[$];
  string         tag_q[$];

  logic          stall_prev = 1'b0;
  logic          stall_hit;
  logic [CW-1:0] stall_code;

  always #10 clk = ~clk;

  tdl_fine_encoder #(.NSEG(NSEG), .SEG_TAPS(SEG)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_taps(in_taps), .out_valid(out_valid), .out_ready(out_ready),
    .out_hit(out_hit), .out_code(out_code)
  );

  // expected result straight from R3..R6
  function automatic void model(input logic [TAPS-1:0] v,
                                output logic hit, output logic [CW-1:0] code);
    hit  = 1'b1;
    code = '0;
    for (int s = 0; s < NSEG; s++) begin
      logic [SEG-1:0] r, m;
      int p;
      r = v[s*SEG +: SEG];
      for (int i = 0; i < SEG; i++) begin
        if (i == 0 || i == SEG - 1) m[i] = r[i];
        else m[i] = (r[i-1] & r[i]) | (r[i-1] & r[i+1]) | (r[i] & r[i+1]);
      end
      p = 0;
      for (int i = SEG - 2; i >= 0; i--) if (m[i] && !m[i+1]) p = i + 1;
      if (p == 0) hit = 1'b0;
      code = code + CW'(p);
    end
    if (!hit) code = '0;
  endfunction

  function automatic logic [TAPS-1:0] therm(input int p0, input int p1,
                                            input int p2, input int p3);
    logic [TAPS-1:0] v;
    int p[4];
    p[0] = p0; p[1] = p1; p[2] = p2; p[3] = p3;
    v = '0;
    for (int s = 0; s < NSEG; s++)
      for (int i = 0; i < SEG; i++) v[s*SEG + i] = (i < p[s]);
    return v;
  endfunction

  task automatic fail(input string tag, input string what, input int act, input int exp);
    n_fail++;
    $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
  endtask

  task automatic step(input logic iv, input logic [TAPS-1:0] tv,
                      input logic ordy, input string tag);
    logic eh;
    logic [CW-1:0] ec;
    @(negedge clk);
    in_valid  = iv;
    in_taps   = tv;
    out_ready = ordy;
    #1;
    n_checks++;  // R2
    if (in_ready !== (out_ready || !out_valid)) fail("R2", "in_ready", in_ready, out_ready || !out_valid);
    if (stall_prev) begin
      n_checks++;  // R8
      if (out_valid !== 1'b1 || out_hit !== stall_hit || out_code !== stall_code)
        fail("R8", "held code", out_code, stall_code);
    end
    stall_prev = out_valid && !out_ready;
    stall_hit  = out_hit;
    stall_code = out_code;
    if (out_valid && out_ready) begin
      n_checks++;
      if (exp_code_q.size() == 0) fail("R9", "extra result", 1, 0);
      else begin
        string t;
        eh = exp_hit_q.pop_front();
        ec = exp_code_q.pop_front();
        t  = tag_q.pop_front();
        if (out_hit !== eh) fail(t, "out_hit", out_hit, eh);
        else if (out_code !== ec) fail(t, "out_code", out_code, ec);
      end
    end
    if (in_valid && in_ready) begin
      model(tv, eh, ec);
      exp_hit_q.push_back(eh);
      exp_code_q.push_back(ec);
      tag_q.push_back(tag);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fail("R9", "watchdog expired", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [TAPS-1:0] v;
    void'($urandom(32'd2025));

    repeat (3) @(negedge clk);
    n_checks++;  // R1 during reset
    if (out_valid !== 1'b0 || in_ready !== 1'b1) fail("R1", "reset state", out_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    n_checks++;  // R1 just after reset
    if (out_valid !== 1'b0 || in_ready !== 1'b1) fail("R1", "post-reset state", out_valid, 0);

    // R7: single snapshot, ready held high
    step(1'b1, therm(10, 20, 30, 40), 1'b1, "R4");
    step(1'b0, '0, 1'b1, "R7");
    n_checks++;
    if (out_valid !== 1'b0) fail("R7", "early out_valid", out_valid, 0);
    step(1'b0, '0, 1'b1, "R7");  // result 100 popped and checked here
    n_checks++;
    if (exp_code_q.size() != 0) fail("R7", "result not out after two stages", exp_code_q.size(), 0);

    // directed corners
    step(1'b1, '0, 1'b1, "R5");                        // all zeros
    step(1'b1, '1, 1'b1, "R5");                        // all ones
    step(1'b1, therm(1, 1, 1, 1), 1'b1, "R6");         // code 4
    step(1'b1, therm(79, 79, 79, 79), 1'b1, "R6");     // code 316
    step(1'b1, therm(40, 0, 40, 40), 1'b1, "R5");      // one empty segment
    step(1'b1, therm(40, 80, 40, 40), 1'b1, "R5");     // one saturated segment
    v = therm(40, 30, 50, 60); v[20] = 1'b0; v[SEG+60] = 1'b1;
    step(1'b1, v, 1'b1, "R3");                         // isolated bubbles, 180
    v = therm(40, 30, 50, 60); v[20] = 1'b0; v[21] = 1'b0;
    step(1'b1, v, 1'b1, "R3");                         // adjacent pair, 160
    v = therm(40, 30, 50, 60); v[0] = 1'b0; v[2*SEG-1] = 1'b1;
    step(1'b1, v, 1'b1, "R3");                         // end taps untouched
    v = therm(79, 1, 79, 1); v[SEG-1] = 1'b1;          // seg0 boundary bit set
    step(1'b1, v, 1'b1, "R3");
    // stall with a result waiting
    step(1'b1, therm(5, 6, 7, 8), 1'b0, "R8");
    step(1'b1, therm(9, 9, 9, 9), 1'b0, "R8");
    step(1'b1, therm(9, 9, 9, 9), 1'b0, "R8");
    step(1'b1, therm(9, 9, 9, 9), 1'b1, "R8");

    // random snapshots with bubbles and back-pressure
    for (int n = 0; n < 1500; n++) begin
      int nb;
      v = therm($urandom % 81, $urandom % 81, $urandom % 81, $urandom % 81);
      nb = $urandom % 4;
      for (int b = 0; b < nb; b++) begin
        int k;
        k = $urandom % TAPS;
        v[k] = ~v[k];
      end
      step(($urandom % 5) != 0, v, ($urandom % 4) != 0, (nb != 0) ? "R3" : "R6");
    end

    repeat (6) step(1'b0, '0, 1'b1, "R9");
    n_checks++;  // R9
    if (exp_code_q.size() != 0) fail("R9", "results missing", exp_code_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule